// File: doc/BRIEF.md
# Dual-Mode Shift/Count Measurement Chain

This block is a single serial chain of flip-flops used both to configure and to read back a grid of delay sensors. Some segments of the chain are plain control registers that drive the settings of noise-generating units and of a clock generator. Other segments are cycle counters, one for each ring-oscillator sensor. Every counter segment also works as an ordinary shift stage. One serial port therefore loads every setting, presets every counter and unloads every measurement.

With `mode` low, the chain is a shift register. On each reference-clock edge where `shift_en` is high, the chain moves one place toward `sdo` and takes `sdi` in at its far end. With `mode` high, the shift path is frozen and the control outputs keep their values. A pulse on `win_start` then opens a measurement window. The window lasts a number of reference cycles held in a dedicated chain segment. While the window is open, each counter counts the rising edges of its own oscillator input. Each oscillator input passes through a synchroniser and is oversampled on the reference clock. A counter that overflows saturates and sets a sticky flag, and that flag is shifted out ahead of the count.

Top module: `sreg_cnt_chain`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every chain bit, so `sdo`, `ctrl_out` and `win_open` all read 0.
- R2: Chain position 0 drives `sdo`. Counter k occupies positions k*(CNT_W+1) to k*(CNT_W+1)+CNT_W: its overflow flag first, then its count with the MSB first. The window-length field follows, MSB first, and then the control field. With `mode`=0 and `shift_en`=1, every position takes the value of the next higher position, and the last position takes `sdi`. With `shift_en`=0 the chain holds.
- R3: In shift mode, `ro_in`, `clr` and `win_start` have no effect on any chain bit, and `win_open` stays 0.
- R4: In count mode (`mode`=1), `shift_en` and `sdi` are ignored, and `ctrl_out` does not change.
- R5: In count mode with the window closed, `win_start` together with a non-zero window length raises `win_open` at the next edge. `win_open` then stays high for exactly that many cycles. A length of 0 never opens the window, and `win_start` while the window is open is ignored.
- R6: An edge sampled with `mode`=0 closes the window, so `win_open` is 0 after that edge.
- R7: `ro_in[k]` is sampled on every rising edge of `clk`. A change from 0 to 1 between the samples at edges t-1 and t adds one to counter k at edge t+2, provided `win_open` was high before edge t+2. The oscillator's high and low phases must each last at least one `clk` period.
- R8: A counter at its all-ones value holds that value on a further counted edge and sets its overflow flag. The flag stays set until it is cleared, reset or overwritten by shifting.
- R9: `clr` in count mode zeroes every counter and overflow flag at that edge and takes priority over counting. It leaves the control and window-length fields untouched.
- R10: Control bit i along the chain, counted from the `sdo` side starting after the window-length field, drives `ctrl_out[NUM_CTRL*CTRL_W-1-i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also serves as the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = shift, 1 = count |
| shift_en | input | 1 | Shift strobe, used in shift mode only |
| sdi | input | 1 | Serial data in, entering at the far end of the chain |
| sdo | output | 1 | Serial data out, taken from chain position 0 |
| clr | input | 1 | Synchronous counter clear, used in count mode only |
| win_start | input | 1 | Opens the measurement window, used in count mode only |
| ro_in | input | NUM_CNT | Ring-oscillator inputs, one per counter |
| ctrl_out | output | NUM_CTRL*CTRL_W | Control field driving noise-source and clock-generator settings |
| win_open | output | 1 | High while the measurement window is open |

## Verification
All outputs come straight from flip-flops. `sdo` and `ctrl_out` move one edge after a shift strobe, and `win_open` rises one edge after `win_start`. An oscillator rise affects a count two edges after the edge that first samples it, and it becomes visible only when the chain is shifted out. The bench keeps a behavioural model that it updates at every rising edge from the inputs set up at the preceding falling edge. It compares `sdo`, `ctrl_out` and `win_open` with that model at each following falling edge, so every result is checked in the cycle it is due. Counter contents are checked bit by bit as they emerge from `sdo` during the next readout.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_COUNT = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/ro_edge_sync.sv
// Brings an oscillator input into the reference domain and flags its rising edges.
module ro_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ro_in,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], ro_in};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/shreg_stage.sv
// Plain shift segment with parallel output (control and window-length fields).
module shreg_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         sout
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (shift) q <= {q[W-2:0], sin};
  end

  assign sout = q[W-1];
endmodule

// File: rtl/cnt_stage.sv
// Counter segment that is also a shift stage: {overflow flag, count}.
module cnt_stage #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic shift,
  input  logic sin,
  input  logic inc,
  output logic sout
);
  localparam int SEG_W = CNT_W + 1;

  logic [SEG_W-1:0] seg;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seg <= '0;
    end else if (shift) begin
      seg <= {seg[SEG_W-2:0], sin};
    end else if (inc) begin
      if (&seg[CNT_W-1:0]) seg[CNT_W] <= 1'b1;
      else                 seg[CNT_W-1:0] <= seg[CNT_W-1:0] + 1'b1;
    end
  end

  assign sout = seg[SEG_W-1];
endmodule

// File: rtl/win_timer.sv
// Measurement window: open for exactly len reference cycles after a start.
module win_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             start,
  input  logic [WIN_W-1:0] len,
  output logic             open
);
  logic [WIN_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      rem  <= '0;
      open <= 1'b0;
    end else if (open) begin
      if (rem == WIN_W'(1)) begin
        rem  <= '0;
        open <= 1'b0;
      end else begin
        rem <= rem - 1'b1;
      end
    end else if (start && (len != '0)) begin
      rem  <= len;
      open <= 1'b1;
    end
  end
endmodule

// File: rtl/sreg_cnt_chain.sv
module sreg_cnt_chain
  import chain_pkg::*;
#(
  parameter int NUM_CNT     = 100,
  parameter int CNT_W       = 16,
  parameter int WIN_W       = 16,
  parameter int NUM_CTRL    = 8,
  parameter int CTRL_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         mode,
  input  logic                         shift_en,
  input  logic                         sdi,
  output logic                         sdo,
  input  logic                         clr,
  input  logic                         win_start,
  input  logic [NUM_CNT-1:0]           ro_in,
  output logic [NUM_CTRL*CTRL_W-1:0]   ctrl_out,
  output logic                         win_open
);
  chain_mode_e mode_e;
  logic        counting, do_shift, do_clr;
  logic [WIN_W-1:0] win_len;
  logic        win_sout;
  logic        ctrl_sout [NUM_CTRL];
  logic        cnt_sout  [NUM_CNT];
  logic        rise      [NUM_CNT];

  assign mode_e   = chain_mode_e'(mode);
  assign counting = (mode_e == MODE_COUNT);
  assign do_shift = !counting && shift_en;
  assign do_clr   = counting && clr;

  // control field: segment 0 takes sdi, the last one feeds the window field
  for (genvar j = 0; j < NUM_CTRL; j++) begin : g_ctrl
    logic sin_j;
    if (j == 0) begin : g_first
      assign sin_j = sdi;
    end else begin : g_next
      assign sin_j = ctrl_sout[j-1];
    end
    shreg_stage #(.W(CTRL_W)) u_ctrl (
      .clk  (clk),
      .rst  (rst),
      .shift(do_shift),
      .sin  (sin_j),
      .q    (ctrl_out[j*CTRL_W +: CTRL_W]),
      .sout (ctrl_sout[j])
    );
  end

  shreg_stage #(.W(WIN_W)) u_win_len (
    .clk  (clk),
    .rst  (rst),
    .shift(do_shift),
    .sin  (ctrl_sout[NUM_CTRL-1]),
    .q    (win_len),
    .sout (win_sout)
  );

  win_timer #(.WIN_W(WIN_W)) u_win (
    .clk  (clk),
    .rst  (rst),
    .arm  (counting),
    .start(win_start),
    .len  (win_len),
    .open (win_open)
  );

  // counters: counter 0 sits at the output end of the chain
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic sin_k;
    if (k == NUM_CNT - 1) begin : g_last
      assign sin_k = win_sout;
    end else begin : g_mid
      assign sin_k = cnt_sout[k+1];
    end
    ro_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .ro_in(ro_in[k]),
      .rise (rise[k])
    );
    cnt_stage #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (do_clr),
      .shift(do_shift),
      .sin  (sin_k),
      .inc  (counting && win_open && rise[k]),
      .sout (cnt_sout[k])
    );
  end

  assign sdo = cnt_sout[0];
endmodule

// File: rtl/chain_sva.sv
module chain_sva #(
  parameter int CTRL_BITS = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 mode,
  input logic                 shift_en,
  input logic                 win_start,
  input logic                 sdo,
  input logic                 win_open,
  input logic [CTRL_BITS-1:0] ctrl_out
);
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    mode |=> $stable(ctrl_out));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!mode && !shift_en) |=> ($stable(sdo) && $stable(ctrl_out)));

  a_r6_close_on_shift: assert property (@(posedge clk) disable iff (rst)
    !mode |=> !win_open);

  a_r5_open_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(win_open) |-> $past(win_start && mode));
endmodule

bind sreg_cnt_chain chain_sva #(.CTRL_BITS(NUM_CTRL*CTRL_W)) u_chain_sva (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .shift_en (shift_en),
  .win_start(win_start),
  .sdo      (sdo),
  .win_open (win_open),
  .ctrl_out (ctrl_out)
);

// File: tb/test_sreg_cnt_chain.sv
`timescale 1ns/1ps
module test_sreg_cnt_chain;
  localparam int NC    = 3;
  localparam int CW    = 4;
  localparam int WW    = 6;
  localparam int NCTL  = 2;
  localparam int CTW   = 4;
  localparam int SEG   = CW + 1;
  localparam int CBITS = NCTL * CTW;
  localparam int CHW   = NC * SEG + WW + CBITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0, shift_en = 1'b0, sdi = 1'b0, clr = 1'b0, win_start = 1'b0;
  logic [NC-1:0] ro_in = '0;
  logic sdo, win_open;
  logic [CBITS-1:0] ctrl_out;

  always #4 clk = ~clk;

  sreg_cnt_chain #(.NUM_CNT(NC), .CNT_W(CW), .WIN_W(WW), .NUM_CTRL(NCTL),
                   .CTRL_W(CTW), .SYNC_STAGES(2)) i_sreg_cnt_chain (
    .clk(clk), .rst(rst), .mode(mode), .shift_en(shift_en), .sdi(sdi), .sdo(sdo),
    .clr(clr), .win_start(win_start), .ro_in(ro_in), .ctrl_out(ctrl_out),
    .win_open(win_open));

  int vectors = 0, errs = 0, cyc = 0, ph = 0;
  bit started = 0, done = 0;
  string tag = "R1";
  int per [NC];
  bit rd [CHW];

  // behavioural reference model
  bit mq [$];
  bit m_open = 0;
  int m_rem = 0;
  logic [NC-1:0] h1 = '0, h2 = '0, h3 = '0, m_e;
  bit m_was;

  function automatic int q_field(int pos, int w);
    int v = 0;
    for (int i = 0; i < w; i++) v = (v << 1) | int'(mq[pos+i]);
    return v;
  endfunction

  function automatic void q_set(int pos, int w, int v);
    for (int i = 0; i < w; i++) mq[pos+i] = bit'((v >> (w-1-i)) & 1);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mq = {};
      for (int i = 0; i < CHW; i++) mq.push_back(1'b0);
      m_open = 0; m_rem = 0; h1 = '0; h2 = '0; h3 = '0;
    end else begin
      m_e = h2 & ~h3;
      m_was = m_open;
      if (!mode) begin
        if (shift_en) begin
          void'(mq.pop_front());
          mq.push_back(sdi);
        end
        m_open = 0; m_rem = 0;
      end else begin
        if (clr) begin
          for (int k = 0; k < NC; k++) q_set(k*SEG, SEG, 0);
        end else if (m_was) begin
          for (int k = 0; k < NC; k++) if (m_e[k]) begin
            if (q_field(k*SEG+1, CW) == (1 << CW) - 1) mq[k*SEG] = 1'b1;
            else q_set(k*SEG+1, CW, q_field(k*SEG+1, CW) + 1);
          end
        end
        if (m_open) begin
          if (m_rem == 1) begin m_open = 0; m_rem = 0; end
          else m_rem--;
        end else if (win_start && q_field(NC*SEG, WW) != 0) begin
          m_open = 1; m_rem = q_field(NC*SEG, WW);
        end
      end
      h3 = h2; h2 = h1; h1 = ro_in;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (started && !done) begin
      chk(tag, "sdo", int'(sdo), int'(mq[0]));
      chk(tag, "ctrl_out", int'(ctrl_out), q_field(NC*SEG+WW, CBITS));
      chk(tag, "win_open", int'(win_open), int'(m_open));
    end
    if (cyc > 20000 && !done) begin
      done = 1; errs++; vectors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  // oscillator stimulus
  always @(negedge clk) begin
    ph++;
    for (int k = 0; k < NC; k++)
      if (per[k] > 0) ro_in[k] = ((ph % per[k]) < per[k] / 2);
  end

  task automatic shift_cfg(int len, int ctl, int c1, int c2);
    bit cfg [CHW];
    for (int i = 0; i < CHW; i++) cfg[i] = 1'b0;
    for (int i = 0; i < CW; i++) begin
      cfg[1*SEG+1+i] = bit'((c1 >> (CW-1-i)) & 1);
      cfg[2*SEG+1+i] = bit'((c2 >> (CW-1-i)) & 1);
    end
    for (int i = 0; i < WW; i++) cfg[NC*SEG+i] = bit'((len >> (WW-1-i)) & 1);
    for (int i = 0; i < CBITS; i++) cfg[NC*SEG+WW+i] = bit'((ctl >> (CBITS-1-i)) & 1);
    mode = 1'b0;
    for (int i = 0; i < CHW; i++) begin
      rd[i] = sdo; sdi = cfg[i]; shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0; sdi = 1'b0;
  endtask

  function automatic int rd_field(int pos, int w);
    int v = 0;
    for (int i = 0; i < w; i++) v = (v << 1) | int'(rd[pos+i]);
    return v;
  endfunction

  initial begin
    per[0] = 4; per[1] = 2; per[2] = 6;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "sdo after reset", int'(sdo), 0);
    chk("R1", "ctrl_out after reset", int'(ctrl_out), 0);
    chk("R1", "win_open after reset", int'(win_open), 0);

    // R2: configure, preset counter1=13, counter2=5, window 40, control A5
    tag = "R2";
    shift_cfg(40, 8'hA5, 13, 5);
    chk("R10", "ctrl_out after load", int'(ctrl_out), 8'hA5);

    // R3: shift mode with noise on clr, win_start, sdi and oscillators
    tag = "R3";
    for (int i = 0; i < 10; i++) begin
      sdi = i[0]; clr = i[1]; win_start = i[2];
      @(negedge clk);
    end
    clr = 0; win_start = 0;
    chk("R3", "win_open in shift mode", int'(win_open), 0);

    // R4: count mode ignores shift strobes
    tag = "R4"; mode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      shift_en = 1'b1; sdi = i[0];
      @(negedge clk);
    end
    shift_en = 0;
    chk("R4", "ctrl_out frozen", int'(ctrl_out), 8'hA5);

    // R7/R8: window of 40 on preset counts
    tag = "R7"; win_start = 1'b1;
    @(negedge clk); win_start = 1'b0;
    chk("R5", "win_open after start", int'(win_open), 1);
    repeat (45) @(negedge clk);
    chk("R5", "win_open after length", int'(win_open), 0);

    // readout while loading next setup: window 5, control 3C
    tag = "R8";
    shift_cfg(5, 8'h3C, 0, 0);
    chk("R8", "counter1 overflow flag", int'(rd[1*SEG]), 1);
    chk("R8", "counter1 saturated", rd_field(1*SEG+1, CW), 15);
    chk("R10", "ctrl_out second load", int'(ctrl_out), 8'h3C);

    // R9 / R5 / R6: clear, window with restart and mid-window clear, abort
    tag = "R9"; mode = 1'b1; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    tag = "R5"; win_start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    tag = "R9"; win_start = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    tag = "R5";
    repeat (6) @(negedge clk);
    tag = "R6"; win_start = 1'b1;
    @(negedge clk); win_start = 1'b0;
    @(negedge clk); mode = 1'b0;
    @(negedge clk);
    chk("R6", "window closed by shift mode", int'(win_open), 0);

    // readout, then load a zero window length
    tag = "R7";
    shift_cfg(0, 8'h0F, 0, 0);
    tag = "R5"; mode = 1'b1; win_start = 1'b1;
    @(negedge clk); win_start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5", "zero length never opens", int'(win_open), 0);

    // clear and verify all counters read zero
    tag = "R9"; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    shift_cfg(0, 0, 0, 0);
    for (int k = 0; k < NC; k++)
      chk("R9", "counter segment after clear", rd_field(k*SEG, SEG), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule